// File: doc/BRIEF.md
# Register-Mapped Multi-Pin GPIO Controller

This block is a bus-slave GPIO controller for a bank of general-purpose pins (95 by default). Software reaches it through a plain register port: an address, a write-data word and a write strobe. A registered read-data word comes back one cycle after the address is presented. Each pin owns a pair of 32-bit configuration words. The first holds the output level, the read-only sampled input level, direction, pin-use selection and trigger kind and polarity. The second holds the input-sense disable and the weak-pull choice.

Beside the per-pin words there are several bitmapped banks, each holding one bit per pin packed into consecutive 32-bit words: firmware ownership, interrupt routing, interrupt status and interrupt enable. There is also a single 32-bit global control word. The controller drives the per-pin output level, output enable, input-sense gate and pull-up and pull-down controls toward the pad ring. It brings the pad input back through a two-stage synchronizer. Interrupt detection and the pad electronics sit outside this block.

Top module: `gpio_ctl`

## Requirements
- R1: After reset every pin is in native mode (use code 0), set as input, with input sensing disabled and no pull. Config word 1 reads 0x0000_0004 and config word 2 reads 0x0000_0004. Every bitmap word and the global word read 0. padOe, senseEn, pullUp and pullDn are all 0.
- R2: Read data is registered and appears one cycle after the address. Address bits [1:0] are ignored. Bitmap bank bases are ownership 0x00, routing 0x10, status 0x80 and enable 0x90. Pin p's bit sits in word p/32 at byte offset (p/32)*4, bit p%32.
- R3: Config word 1 of pin p sits at 0x100 + 8*p. Its writable fields are bit 31 (output level), bit 4 (trigger: 0 edge, 1 level), bit 3 (trigger invert), bit 2 (direction: 1 input, 0 output) and bits 1:0 (use: 0 native, 1 GPIO). All other bits except bit 30 read 0.
- R4: Bit 30 of config word 1 is read-only. It returns the pad input after two synchronizing flops, or 0 while input sensing of that pin is disabled. Writes to it are ignored.
- R5: Config word 2 of pin p sits at 0x104 + 8*p. Bit 2 set disables input sensing and drives senseEn low. Bits 1:0 select the pull: 0 none, 1 pull-down (pullDn), 2 pull-up (pullUp), 3 drives neither. All other bits read 0.
- R6: padOe of a pin is high exactly when its use code is 1 and its direction bit is 0. padOut follows its output-level bit.
- R7: Unmapped addresses read 0 and writes to them change nothing. This covers word 3 of any bank (0x0C, 0x1C, 0x8C, 0x9C), config words of pins at or above the pin count (from 0x3F8), and any other offset. Bitmap bits of pins beyond the last pin read 0.
- R8: An enable bit can be set only for a pin whose ownership bit is 1, because ownership 0 reserves the pin for firmware. Clearing an ownership bit clears that pin's enable bit in the same cycle.
- R9: The routing and status bitmaps and the global control word at 0x7C are plain read/write storage, subject to R7's masking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Byte address of the register access |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write strobe for the addressed register |
| rdData | output | 32 | Registered read data of the previous cycle's address |
| padIn | input | 95 | Asynchronous pad input levels |
| padOut | output | 95 | Output level per pin |
| padOe | output | 95 | Output enable per pin |
| senseEn | output | 95 | Input-sense gate per pin |
| pullUp | output | 95 | Weak pull-up request per pin |
| pullDn | output | 95 | Weak pull-down request per pin |

## Verification
The bench walks every pin's two config words with per-pin varying field patterns. Each readback is checked along with the pin's output enable, level, pull and sense outputs, which catches a wrong stride, a swapped word or an output enable decoded from the wrong bits. It probes the boundaries of the address map: the unused fourth bank word, the slot one past the last pin, and the top bit of the last bitmap word. A decoder that aliased or failed to mask there would show stored data or corrupt a real pin. It sets the read-only input bit through writes and toggles the pad under both sense settings, so storing that bit or ignoring the gate gives a mismatch. It also checks that clearing ownership strips a stale enable bit, which a design that only masked enable writes would miss.

// File: rtl/gpio_ctl_pkg.sv
package gpio_ctl_pkg;

  // Index widths carried in the strobe bundle (support up to 128 pins, 4 words per bank)
  localparam int PIN_IDX_W  = 7;
  localparam int WORD_IDX_W = 2;

  // Bank base offsets (bytes)
  localparam int OWN_BASE   = 'h00;
  localparam int ROUTE_BASE = 'h10;
  localparam int GLOB_OFF   = 'h7C;
  localparam int STAT_BASE  = 'h80;
  localparam int EN_BASE    = 'h90;
  localparam int CFG_BASE   = 'h100;

  // Config word 1 bit positions
  localparam int B_OUTLVL = 31;
  localparam int B_INLVL  = 30;
  localparam int B_TRIG   = 4;
  localparam int B_INV    = 3;
  localparam int B_DIR    = 2;

  // Config word 2 bit positions
  localparam int B_INDIS  = 2;

  localparam logic [1:0] USE_NATIVE = 2'd0;
  localparam logic [1:0] USE_GPIO   = 2'd1;
  localparam logic [1:0] PULL_NONE  = 2'd0;
  localparam logic [1:0] PULL_DOWN  = 2'd1;
  localparam logic [1:0] PULL_UP    = 2'd2;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_OWN, SEL_ROUTE, SEL_GLOB, SEL_STAT, SEL_EN, SEL_CFG1, SEL_CFG2
  } regSel_e;

  typedef struct packed {
    regSel_e                sel;
    logic                   wr;
    logic [WORD_IDX_W-1:0]  word;
    logic [PIN_IDX_W-1:0]   pin;
  } strobe_t;

endpackage

// File: rtl/gpio_ctl_decode.sv
module gpio_ctl_decode
  import gpio_ctl_pkg::*;
#(
  parameter int NPINS  = 95,
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobe_t           stb
);

  localparam int NWORDS = (NPINS + 31) / 32;

  logic [ADDR_W-1:0] cfgOff;
  logic [ADDR_W-4:0] cfgPin;
  logic [ADDR_W-5:0] bankSel;
  logic [1:0]        wordIdx;
  logic              unusedAddr;

  assign unusedAddr = ^{busAddr[1:0], cfgOff[2:0]};

  always_comb begin
    cfgOff  = busAddr - ADDR_W'(CFG_BASE);
    cfgPin  = cfgOff[ADDR_W-1:3];
    bankSel = busAddr[ADDR_W-1:4];
    wordIdx = busAddr[3:2];
    stb     = '0;
    stb.wr  = busWe;
    if (busAddr >= ADDR_W'(CFG_BASE)) begin
      // per-pin pair: word 1 at +0, word 2 at +4, stride 8
      if (int'(cfgPin) < NPINS) begin
        stb.sel = busAddr[2] ? SEL_CFG2 : SEL_CFG1;
        stb.pin = PIN_IDX_W'(cfgPin);
      end
    end else if (busAddr[ADDR_W-1:2] == (ADDR_W-2)'(GLOB_OFF >> 2)) begin
      stb.sel = SEL_GLOB;
    end else if (int'(wordIdx) < NWORDS) begin
      stb.word = wordIdx;
      if (bankSel == (ADDR_W-4)'(OWN_BASE >> 4))        stb.sel = SEL_OWN;
      else if (bankSel == (ADDR_W-4)'(ROUTE_BASE >> 4)) stb.sel = SEL_ROUTE;
      else if (bankSel == (ADDR_W-4)'(STAT_BASE >> 4))  stb.sel = SEL_STAT;
      else if (bankSel == (ADDR_W-4)'(EN_BASE >> 4))    stb.sel = SEL_EN;
    end
  end

endmodule

// File: rtl/gpio_ctl_regs.sv
module gpio_ctl_regs
  import gpio_ctl_pkg::*;
#(
  parameter int NPINS = 95
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  input  logic [31:0]      busWdata,
  input  logic [NPINS-1:0] padIn,
  output logic [31:0]      rdData,
  output logic [NPINS-1:0] padOut,
  output logic [NPINS-1:0] padOe,
  output logic [NPINS-1:0] senseEn,
  output logic [NPINS-1:0] pullUp,
  output logic [NPINS-1:0] pullDn
);

  localparam int NWORDS = (NPINS + 31) / 32;

  function automatic logic [31:0] wordMask(input int w);
    logic [31:0] m;
    for (int b = 0; b < 32; b++) m[b] = (w * 32 + b) < NPINS;
    return m;
  endfunction

  // per-pin configuration state
  logic [NPINS-1:0]      outLvl, trigLvl, trigInv, dirIn, inDis;
  logic [NPINS-1:0][1:0] useSel, pullSel;
  // bitmapped banks and global word
  logic [NWORDS-1:0][31:0] ownW, routeW, statW, enW;
  logic [31:0]             globW;
  // input synchronizer
  logic [NPINS-1:0] inSync1, inSync2;
  logic [31:0]      rdNext;
  logic [31:0]      curMask;

  assign curMask = wordMask(int'(stb.word));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inSync1 <= '0;
      inSync2 <= '0;
    end else begin
      inSync1 <= padIn;
      inSync2 <= inSync1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outLvl  <= '0;
      trigLvl <= '0;
      trigInv <= '0;
      dirIn   <= '1;
      inDis   <= '1;
      useSel  <= '0;
      pullSel <= '0;
      ownW    <= '0;
      routeW  <= '0;
      statW   <= '0;
      enW     <= '0;
      globW   <= '0;
    end else if (stb.wr) begin
      case (stb.sel)
        SEL_OWN: begin
          ownW[stb.word] <= busWdata & curMask;
          enW[stb.word]  <= enW[stb.word] & busWdata & curMask;
        end
        SEL_ROUTE: routeW[stb.word] <= busWdata & curMask;
        SEL_STAT:  statW[stb.word]  <= busWdata & curMask;
        SEL_EN:    enW[stb.word]    <= busWdata & curMask & ownW[stb.word];
        SEL_GLOB:  globW            <= busWdata;
        SEL_CFG1: begin
          outLvl[stb.pin]  <= busWdata[B_OUTLVL];
          trigLvl[stb.pin] <= busWdata[B_TRIG];
          trigInv[stb.pin] <= busWdata[B_INV];
          dirIn[stb.pin]   <= busWdata[B_DIR];
          useSel[stb.pin]  <= busWdata[1:0];
        end
        SEL_CFG2: begin
          inDis[stb.pin]   <= busWdata[B_INDIS];
          pullSel[stb.pin] <= busWdata[1:0];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdNext = '0;
    case (stb.sel)
      SEL_OWN:   rdNext = ownW[stb.word];
      SEL_ROUTE: rdNext = routeW[stb.word];
      SEL_STAT:  rdNext = statW[stb.word];
      SEL_EN:    rdNext = enW[stb.word];
      SEL_GLOB:  rdNext = globW;
      SEL_CFG1: begin
        rdNext[B_OUTLVL] = outLvl[stb.pin];
        rdNext[B_INLVL]  = inSync2[stb.pin] & ~inDis[stb.pin];
        rdNext[B_TRIG]   = trigLvl[stb.pin];
        rdNext[B_INV]    = trigInv[stb.pin];
        rdNext[B_DIR]    = dirIn[stb.pin];
        rdNext[1:0]      = useSel[stb.pin];
      end
      SEL_CFG2: begin
        rdNext[B_INDIS]  = inDis[stb.pin];
        rdNext[1:0]      = pullSel[stb.pin];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign padOut[i]  = outLvl[i];
    assign padOe[i]   = (useSel[i] == USE_GPIO) && !dirIn[i];
    assign senseEn[i] = !inDis[i];
    assign pullUp[i]  = (pullSel[i] == PULL_UP);
    assign pullDn[i]  = (pullSel[i] == PULL_DOWN);
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (padOe == '0 && senseEn == '0 && pullUp == '0));
  // R2
  bank_word_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sel inside {SEL_OWN, SEL_ROUTE, SEL_STAT, SEL_EN}) |-> (int'(stb.word) < NWORDS));
  // R5
  pull_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pullUp & pullDn) == '0);
  // R6
  oe_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.wr) |-> $stable(padOe));
  // R7
  cfg_pin_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.sel inside {SEL_CFG1, SEL_CFG2}) |-> (int'(stb.pin) < NPINS));
  // R8
  en_owned_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enW & ~ownW) == '0);

endmodule

// File: rtl/gpio_ctl.sv
module gpio_ctl
  import gpio_ctl_pkg::*;
#(
  parameter int NPINS  = 95,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic              busWe,
  output logic [31:0]       rdData,
  input  logic [NPINS-1:0]  padIn,
  output logic [NPINS-1:0]  padOut,
  output logic [NPINS-1:0]  padOe,
  output logic [NPINS-1:0]  senseEn,
  output logic [NPINS-1:0]  pullUp,
  output logic [NPINS-1:0]  pullDn
);

  strobe_t stb;

  gpio_ctl_decode #(.NPINS(NPINS), .ADDR_W(ADDR_W)) decode_i (
    .busAddr (busAddr),
    .busWe   (busWe),
    .stb     (stb)
  );

  gpio_ctl_regs #(.NPINS(NPINS)) regs_i (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .busWdata (busWdata),
    .padIn    (padIn),
    .rdData   (rdData),
    .padOut   (padOut),
    .padOe    (padOe),
    .senseEn  (senseEn),
    .pullUp   (pullUp),
    .pullDn   (pullDn)
  );

endmodule

// File: tb/gpio_ctl_tb_top.sv
module gpio_ctl_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NP = 95;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [11:0]   busAddr = '0;
  logic [31:0]   busWdata = '0;
  logic          busWe = 1'b0;
  logic [31:0]   rdData;
  logic [NP-1:0] padIn = '0;
  logic [NP-1:0] padOut, padOe, senseEn, pullUp, pullDn;

  int nTests = 0;
  int nFail  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  gpio_ctl dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe),
    .rdData(rdData), .padIn(padIn), .padOut(padOut), .padOe(padOe),
    .senseEn(senseEn), .pullUp(pullUp), .pullDn(pullDn)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    @(negedge clk);
    busAddr = 12'(addr); busWdata = data; busWe = 1'b1;
    @(posedge clk);
    #1 busWe = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [31:0] data);
    @(negedge clk);
    busAddr = 12'(addr); busWe = 1'b0;
    @(posedge clk);
    #1 data = rdData;
  endtask

  function automatic logic [31:0] maskOf(input int w);
    logic [31:0] m;
    for (int b = 0; b < 32; b++) m[b] = (w * 32 + b) < NP;
    return m;
  endfunction

  function automatic logic [31:0] cfg1Val(input int p);
    return (32'(p / 8 % 2) << 31) | (32'(1) << 30) | (32'(1) << 17) |
           (32'(p / 2 % 2) << 4) | (32'(p / 16 % 2) << 3) |
           (32'(p / 4 % 2) << 2) | 32'(p % 4);
  endfunction

  function automatic logic [31:0] cfg2Val(input int p);
    return (32'(1) << 9) | (32'(p % 3 == 0) << 2) | 32'(p % 4);
  endfunction

  initial begin
    logic [31:0] d;
    int banks[4];
    banks = '{'h00, 'h10, 'h80, 'h90};

    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state
    rd('h100, d);            chk("R1 cfg1 pin0", d, 32'h4);
    rd('h100 + 94 * 8, d);   chk("R1 cfg1 pin94", d, 32'h4);
    rd('h104 + 50 * 8, d);   chk("R1 cfg2 pin50", d, 32'h4);
    rd('h00, d);             chk("R1 own word0", d, 0);
    rd('h7C, d);             chk("R1 global", d, 0);
    chk("R1 padOe", 32'(padOe != '0), 0);
    chk("R1 senseEn", 32'(senseEn != '0), 0);
    chk("R1 pulls", 32'((pullUp | pullDn) != '0), 0);

    // R3 R5 R6 sweep over every pin
    for (int p = 0; p < NP; p++) begin
      logic [31:0] v1, v2;
      v1 = cfg1Val(p);
      v2 = cfg2Val(p);
      wr('h100 + p * 8, v1);
      wr('h104 + p * 8, v2);
      rd('h100 + p * 8, d);
      chk($sformatf("R3 cfg1 pin%0d", p), d, v1 & 32'h8000_001F);
      rd('h104 + p * 8, d);
      chk($sformatf("R5 cfg2 pin%0d", p), d, v2 & 32'h7);
      chk($sformatf("R6 oe pin%0d", p), 32'(padOe[p]), 32'((p % 4 == 1) && (p / 4 % 2 == 0)));
      chk($sformatf("R6 out pin%0d", p), 32'(padOut[p]), 32'(p / 8 % 2));
      chk($sformatf("R5 sense pin%0d", p), 32'(senseEn[p]), 32'(p % 3 != 0));
      chk($sformatf("R5 pullUp pin%0d", p), 32'(pullUp[p]), 32'(p % 4 == 2));
      chk($sformatf("R5 pullDn pin%0d", p), 32'(pullDn[p]), 32'(p % 4 == 1));
    end

    // R2 byte offset ignored
    rd('h103, d); chk("R2 byte lanes ignored", d, cfg1Val(0) & 32'h8000_001F);

    // R4 input level through synchronizer, gated by sense
    @(negedge clk) padIn = '1;
    repeat (3) @(posedge clk);
    for (int p = 0; p < NP; p++) begin
      rd('h100 + p * 8, d);
      chk($sformatf("R4 inlvl high pin%0d", p), d,
          (cfg1Val(p) & 32'h8000_001F) | (32'(p % 3 != 0) << 30));
    end
    @(negedge clk) padIn = '0;
    repeat (3) @(posedge clk);
    rd('h100 + 1 * 8, d);
    chk("R4 inlvl low pin1", d, cfg1Val(1) & 32'h8000_001F);

    // R2 R9 bitmap banks, including last-word masking; own written first
    for (int b = 0; b < 4; b++) begin
      for (int w = 0; w < 3; w++) begin
        logic [31:0] pat;
        pat = 32'hF5C3_0F96 ^ (32'h1111_1111 * 32'(w + b));
        wr(banks[b] + w * 4, pat);
      end
    end
    for (int b = 0; b < 4; b++) begin
      for (int w = 0; w < 3; w++) begin
        logic [31:0] pat, own;
        pat = 32'hF5C3_0F96 ^ (32'h1111_1111 * 32'(w + b));
        own = 32'hF5C3_0F96 ^ (32'h1111_1111 * 32'(w));
        rd(banks[b] + w * 4, d);
        if (b == 3) chk($sformatf("R8 enable masked by owner w%0d", w), d, pat & own & maskOf(w));
        else        chk($sformatf("R2 R9 bank%0d w%0d", b, w), d, pat & maskOf(w));
      end
    end

    // R8 clearing ownership strips enable
    wr('h04, 32'h0000_FFFF);
    rd('h94, d);
    chk("R8 enable cleared with owner", d,
        (32'hF5C3_0F96 ^ (32'h1111_1111 * 32'd4)) & (32'hF5C3_0F96 ^ 32'h1111_1111) & 32'h0000_FFFF);
    wr('h94, 32'hFFFF_FFFF);
    rd('h94, d); chk("R8 enable limited to owned", d, 32'h0000_FFFF);

    // R9 global word
    wr('h7C, 32'hDEAD_BEEF);
    rd('h7C, d); chk("R9 global rw", d, 32'hDEAD_BEEF);

    // R7 unmapped reads and writes
    wr('h0C, 32'hFFFF_FFFF);
    rd('h0C, d); chk("R7 bank word3 reads zero", d, 0);
    rd('h00, d); chk("R7 word3 write no alias", d, 32'hF5C3_0F96);
    wr('h20, 32'hFFFF_FFFF);
    rd('h20, d); chk("R7 gap reads zero", d, 0);
    rd('hA0, d); chk("R7 above enable reads zero", d, 0);
    rd('h9C, d); chk("R7 enable word3 zero", d, 0);
    wr('h100 + 95 * 8, 32'hFFFF_FFFF);
    wr('h104 + 95 * 8, 32'hFFFF_FFFF);
    rd('h100 + 95 * 8, d); chk("R7 pin95 cfg1 zero", d, 0);
    rd('h104 + 95 * 8, d); chk("R7 pin95 cfg2 zero", d, 0);
    rd('h100 + 94 * 8, d); chk("R7 pin94 untouched", d, cfg1Val(94) & 32'h8000_001F);
    rd('h100, d);          chk("R7 pin0 untouched", d, cfg1Val(0) & 32'h8000_001F);

    // R6 output enable follows later reconfiguration
    wr('h100 + 9 * 8, 32'h8000_0001);
    chk("R6 oe gpio output", 32'(padOe[9]), 1);
    chk("R6 out level", 32'(padOut[9]), 1);
    wr('h100 + 9 * 8, 32'h0000_0005);
    chk("R6 oe off when input", 32'(padOe[9]), 0);
    wr('h100 + 9 * 8, 32'h0000_0002);
    chk("R6 oe off in other use", 32'(padOe[9]), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule